// File: doc/BRIEF.md
# SECDED Memory-Path Error Codec

This block protects a 32-bit memory data path with an 8-bit single-error-correcting, double-error-detecting code. On the write side it turns a 32-bit word into 8 check bits, which are stored next to the data. On the read side it takes the 32 data bits and the 8 check bits read back together. It corrects any single flipped bit before the word reaches the requester, and it reports words that cannot be repaired. The code is defined over a 64-bit word. The upper 32 bits are tied to zero inside the block, so every check bit must be stored and returned for checking to work. The block never writes anything back to memory on its own.

The write encoder is purely combinational. The read path has one register stage. Its heart is an event register with four states: `EV_CLEAN`, `EV_FIX_DATA`, `EV_FIX_CHECK` and `EV_FATAL`. Reset places it in `EV_CLEAN`. On each cycle with `rd_valid` high it moves to the state the syndrome decoder chose for that word, which can be any of the four from any of the four. On idle cycles it holds its state. The status pulses come from this state and are gated by the registered valid, so an idle cycle never raises a flag.

Top module: `secded_mem_codec`

## Requirements
- R1: `wr_check` is combinational. Bit j is the XOR of every data bit i (0..31) whose column has bit j set. Column i is the i-th 8-bit value in increasing numeric order with exactly three ones. Later positions continue with the five-one values and then the seven-one values. Positions 32..63 are zero in the code word, and check bit j's own column is the one-hot value with bit j set.
- R2: `out_syndrome` equals `rd_check` XOR the check bits recomputed from `rd_data`. It is registered one cycle after `rd_valid`.
- R3: A zero syndrome returns `rd_data` unchanged, with `out_corrected` and `out_uncorrectable` both low.
- R4: A syndrome equal to the column of data bit i (0..31) returns `rd_data` with bit i inverted and pulses `out_corrected`.
- R5: A one-hot syndrome, meaning a single check-bit error, returns `rd_data` unchanged and pulses `out_corrected`.
- R6: A nonzero syndrome with an even number of ones, such as any double error, pulses `out_uncorrectable`. `rd_data` is returned unchanged and `out_corrected` stays low.
- R7: A syndrome equal to the column of a zero-padded position (32..63) pulses `out_uncorrectable` and corrects nothing.
- R8: On a cycle after `rd_valid` was low, `out_valid`, `out_corrected` and `out_uncorrectable` are low, and `out_data` and `out_syndrome` hold their values.
- R9: Results appear exactly one cycle after `rd_valid`. Back-to-back reads are each reported in their own cycle, and the write encoder works during the same cycles as a read.
- R10: While `rst_n` is low, every read output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data | input | 32 | Data word to be written |
| wr_check | output | 8 | Check bits to store with `wr_data` |
| rd_valid | input | 1 | Read word present this cycle |
| rd_data | input | 32 | Data bits read from memory |
| rd_check | input | 8 | Check bits read from memory |
| out_valid | output | 1 | Registered read result valid |
| out_data | output | 32 | Corrected (or raw, if uncorrectable) read data |
| out_corrected | output | 1 | Single-bit error repaired in this result |
| out_uncorrectable | output | 1 | Error detected that cannot be repaired |
| out_syndrome | output | 8 | Syndrome of the reported read |

## Verification
Two functions can fall in the same cycle. The combinational write encoder can run while a read is being decoded. A read whose result is still being reported can also overlap the next read entering the register. The bench drives a fresh `wr_data` in the same cycle as a read that carries a single-bit error, and judges both `wr_check` and the corrected result against values it computes itself. It also issues three reads in consecutive cycles (corrected, uncorrectable, clean) and checks that each result's flags and data belong only to its own word.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int ECC_DATA_W = 32;
    localparam int ECC_WORD_W = 64;
    localparam int ECC_CHK_W  = 8;

    typedef enum logic [1:0] {
        EV_CLEAN     = 2'd0,
        EV_FIX_DATA  = 2'd1,
        EV_FIX_CHECK = 2'd2,
        EV_FATAL     = 2'd3
    } ecc_event_e;

    // Column of code-word position idx: odd-weight values, weight 3 first,
    // each weight class taken in increasing numeric order.
    function automatic logic [ECC_CHK_W-1:0] hsiao_col(input int idx);
        logic [ECC_CHK_W-1:0] res;
        logic [ECC_CHK_W-1:0] cand;
        int seen;
        res  = '0;
        seen = 0;
        for (int w = 3; w <= ECC_CHK_W; w += 2) begin
            for (int v = 1; v < (1 << ECC_CHK_W); v++) begin
                cand = v[ECC_CHK_W-1:0];
                if ($countones(cand) == w) begin
                    if (seen == idx) res = cand;
                    seen++;
                end
            end
        end
        return res;
    endfunction

    // Positions of the 64-bit word that feed check bit bit_j.
    function automatic logic [ECC_WORD_W-1:0] row_mask(input int bit_j);
        logic [ECC_WORD_W-1:0] m;
        logic [ECC_CHK_W-1:0]  c;
        m = '0;
        for (int i = 0; i < ECC_WORD_W; i++) begin
            c    = hsiao_col(i);
            m[i] = c[bit_j];
        end
        return m;
    endfunction

endpackage

// File: rtl/ecc_check_gen.sv
module ecc_check_gen
    import secded_pkg::*;
#(
    parameter int DATA_W = ECC_DATA_W,
    parameter int WORD_W = ECC_WORD_W,
    parameter int CHK_W  = ECC_CHK_W
) (
    input  logic [DATA_W-1:0] data_in,
    output logic [CHK_W-1:0]  check_out
);

    localparam int PAD_W = WORD_W - DATA_W;

    logic [WORD_W-1:0] code_word;

    // Upper half of the code word is tied to zero.
    assign code_word = {{PAD_W{1'b0}}, data_in};

    for (genvar j = 0; j < CHK_W; j++) begin : g_row
        localparam logic [WORD_W-1:0] ROW = row_mask(j);
        assign check_out[j] = ^(code_word & ROW);
    end

endmodule

// File: rtl/ecc_syndrome_decode.sv
module ecc_syndrome_decode
    import secded_pkg::*;
#(
    parameter int DATA_W = ECC_DATA_W,
    parameter int WORD_W = ECC_WORD_W,
    parameter int CHK_W  = ECC_CHK_W
) (
    input  logic [CHK_W-1:0]  syndrome,
    output logic [DATA_W-1:0] flip_mask,
    output logic              pad_hit,
    output ecc_event_e        ev_kind
);

    logic [WORD_W-1:0] col_hit;
    logic              check_hit;

    for (genvar i = 0; i < WORD_W; i++) begin : g_col
        localparam logic [CHK_W-1:0] COL = hsiao_col(i);
        assign col_hit[i] = (syndrome == COL);
    end

    assign flip_mask = col_hit[DATA_W-1:0];
    assign pad_hit   = |col_hit[WORD_W-1:DATA_W];
    assign check_hit = $onehot(syndrome);

    always_comb begin
        if (syndrome == '0)
            ev_kind = EV_CLEAN;
        else if (|flip_mask)
            ev_kind = EV_FIX_DATA;
        else if (check_hit)
            ev_kind = EV_FIX_CHECK;
        else
            ev_kind = EV_FATAL;   // even weight, padded column, or unknown
    end

endmodule

// File: rtl/ecc_read_stage.sv
module ecc_read_stage
    import secded_pkg::*;
#(
    parameter int DATA_W = ECC_DATA_W,
    parameter int CHK_W  = ECC_CHK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] raw_data,
    input  logic [CHK_W-1:0]  syndrome,
    input  logic [DATA_W-1:0] flip_mask,
    input  ecc_event_e        ev_kind,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_corrected,
    output logic              out_uncorrectable,
    output logic [CHK_W-1:0]  out_syndrome
);

    ecc_event_e        ev_q;
    logic              vld_q;
    logic [DATA_W-1:0] data_q;
    logic [CHK_W-1:0]  syn_q;

    // State register: follows the decoder verdict on accepted reads only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q   <= EV_CLEAN;
            vld_q  <= 1'b0;
            data_q <= '0;
            syn_q  <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                ev_q   <= ev_kind;
                data_q <= raw_data ^ flip_mask;
                syn_q  <= syndrome;
            end
        end
    end

    // Outputs: status pulses gated by the registered valid.
    always_comb begin
        out_corrected     = 1'b0;
        out_uncorrectable = 1'b0;
        unique case (ev_q)
            EV_CLEAN:                  ;
            EV_FIX_DATA, EV_FIX_CHECK: out_corrected     = vld_q;
            EV_FATAL:                  out_uncorrectable = vld_q;
            default:                   ;
        endcase
    end

    assign out_valid    = vld_q;
    assign out_data     = data_q;
    assign out_syndrome = syn_q;

    a_r3_clean_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && syndrome == '0) |=>
            (out_data == $past(raw_data)) && !out_corrected && !out_uncorrectable);

    a_r4_single_data_fix: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && $onehot(flip_mask)) |=>
            out_corrected && !out_uncorrectable &&
            ($countones(out_data ^ $past(raw_data)) == 1));

    a_r5_check_bit_fix: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && $onehot(syndrome)) |=>
            out_corrected && (out_data == $past(raw_data)));

    a_r6_even_weight_fatal: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && syndrome != '0 && ($countones(syndrome) % 2 == 0)) |=>
            out_uncorrectable && !out_corrected && (out_data == $past(raw_data)));

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=>
            !out_valid && !out_corrected && !out_uncorrectable &&
            $stable(out_data) && $stable(out_syndrome));

    a_r2_syndrome_latched: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid && (out_syndrome == $past(syndrome)));

endmodule

// File: rtl/secded_mem_codec.sv
module secded_mem_codec
    import secded_pkg::*;
#(
    parameter int DATA_W = ECC_DATA_W,
    parameter int WORD_W = ECC_WORD_W,
    parameter int CHK_W  = ECC_CHK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CHK_W-1:0]  wr_check,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [CHK_W-1:0]  rd_check,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_corrected,
    output logic              out_uncorrectable,
    output logic [CHK_W-1:0]  out_syndrome
);

    logic [CHK_W-1:0]  rd_recalc;
    logic [CHK_W-1:0]  syndrome;
    logic [DATA_W-1:0] flip_mask;
    logic              pad_hit;
    ecc_event_e        ev_kind;

    ecc_check_gen #(.DATA_W(DATA_W), .WORD_W(WORD_W), .CHK_W(CHK_W)) u_wr_gen (
        .data_in   (wr_data),
        .check_out (wr_check)
    );

    ecc_check_gen #(.DATA_W(DATA_W), .WORD_W(WORD_W), .CHK_W(CHK_W)) u_rd_gen (
        .data_in   (rd_data),
        .check_out (rd_recalc)
    );

    assign syndrome = rd_check ^ rd_recalc;

    ecc_syndrome_decode #(.DATA_W(DATA_W), .WORD_W(WORD_W), .CHK_W(CHK_W)) u_dec (
        .syndrome  (syndrome),
        .flip_mask (flip_mask),
        .pad_hit   (pad_hit),
        .ev_kind   (ev_kind)
    );

    ecc_read_stage #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_stage (
        .clk               (clk),
        .rst_n             (rst_n),
        .in_valid          (rd_valid),
        .raw_data          (rd_data),
        .syndrome          (syndrome),
        .flip_mask         (flip_mask),
        .ev_kind           (ev_kind),
        .out_valid         (out_valid),
        .out_data          (out_data),
        .out_corrected     (out_corrected),
        .out_uncorrectable (out_uncorrectable),
        .out_syndrome      (out_syndrome)
    );

    a_r7_padded_fatal: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && pad_hit) |=>
            out_uncorrectable && !out_corrected && (out_data == $past(rd_data)));

endmodule

// File: tb/secded_mem_codec_test.sv
module secded_mem_codec_test;

    logic        clk;
    logic        rst_n;
    logic [31:0] wr_data;
    logic [7:0]  wr_check;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [7:0]  rd_check;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_corrected;
    logic        out_uncorrectable;
    logic [7:0]  out_syndrome;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    secded_mem_codec uut (
        .clk(clk), .rst_n(rst_n),
        .wr_data(wr_data), .wr_check(wr_check),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_check(rd_check),
        .out_valid(out_valid), .out_data(out_data),
        .out_corrected(out_corrected), .out_uncorrectable(out_uncorrectable),
        .out_syndrome(out_syndrome)
    );

    initial begin
        clk = 1'b0;
        forever #4 clk = ~clk;
    end

    // Column n per R1: weight-3 values ascending, then weight-5, then weight-7.
    function automatic logic [7:0] ref_col(input int n);
        int k = 0;
        for (int w = 3; w <= 7; w += 2) begin
            for (int v = 1; v < 256; v++) begin
                int ones = 0;
                for (int b = 0; b < 8; b++) ones += (v >> b) & 1;
                if (ones == w) begin
                    if (k == n) return v[7:0];
                    k++;
                end
            end
        end
        return 8'h00;
    endfunction

    function automatic logic [7:0] ref_enc(input logic [31:0] d);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < 32; i++) if (d[i]) c ^= ref_col(i);
        return c;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive one read at a falling edge; results are sampled one edge later.
    task automatic do_read(input string req, input logic [31:0] d, input logic [7:0] c,
                           input logic [31:0] exp_d, input logic exp_corr,
                           input logic exp_unc);
        logic [7:0] exp_syn;
        exp_syn  = c ^ ref_enc(d);
        rd_valid = 1'b1;
        rd_data  = d;
        rd_check = c;
        @(negedge clk);
        check(req, "out_valid", 64'(out_valid), 64'(1'b1));
        check(req, "out_data", 64'(out_data), 64'(exp_d));
        check(req, "out_corrected", 64'(out_corrected), 64'(exp_corr));
        check(req, "out_uncorrectable", 64'(out_uncorrectable), 64'(exp_unc));
        check("R2", "out_syndrome", 64'(out_syndrome), 64'(exp_syn));
    endtask

    task automatic go_idle();
        rd_valid = 1'b0;
        rd_data  = 32'hDEAD_BEEF;
        rd_check = 8'hFF;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; rd_valid = 1'b1; rd_data = 32'h1234_5678; rd_check = 8'h5A;
        wr_data = 32'h0;
        repeat (3) @(negedge clk);
        check("R10", "out_valid", 64'(out_valid), 0);
        check("R10", "out_data", 64'(out_data), 0);
        check("R10", "out_corrected", 64'(out_corrected), 0);
        check("R10", "out_uncorrectable", 64'(out_uncorrectable), 0);
        check("R10", "out_syndrome", 64'(out_syndrome), 0);
        rst_n = 1'b1;
        go_idle();
    endtask

    task automatic t_encode();
        logic [31:0] pats [6] = '{32'h0, 32'hFFFF_FFFF, 32'hA5A5_A5A5,
                                  32'h0000_0001, 32'h8000_0000, 32'h1357_9BDF};
        foreach (pats[p]) begin
            wr_data = pats[p];
            #1;
            check("R1", "wr_check", 64'(wr_check), 64'(ref_enc(pats[p])));
        end
        @(negedge clk);
    endtask

    task automatic t_clean();
        do_read("R3", 32'h0, 8'h00, 32'h0, 1'b0, 1'b0);
        do_read("R3", 32'hCAFE_F00D, ref_enc(32'hCAFE_F00D), 32'hCAFE_F00D, 1'b0, 1'b0);
        go_idle();
    endtask

    task automatic t_single_data();
        int bits [3] = '{0, 15, 31};
        logic [31:0] d = 32'h6B3D_91E4;
        foreach (bits[b]) begin
            do_read("R4", d ^ (32'h1 << bits[b]), ref_enc(d), d, 1'b1, 1'b0);
        end
        go_idle();
    endtask

    task automatic t_single_check();
        logic [31:0] d = 32'h0F1E_2D3C;
        for (int j = 0; j < 8; j++) begin
            do_read("R5", d, ref_enc(d) ^ (8'h1 << j), d, 1'b1, 1'b0);
        end
        go_idle();
    endtask

    task automatic t_double();
        logic [31:0] d = 32'h7777_1111;
        logic [31:0] bad;
        bad = d ^ 32'h0000_0003;
        do_read("R6", bad, ref_enc(d), bad, 1'b0, 1'b1);
        bad = d ^ 32'h8000_0400;
        do_read("R6", bad, ref_enc(d), bad, 1'b0, 1'b1);
        bad = d ^ 32'h0001_0000;
        do_read("R6", bad, ref_enc(d) ^ 8'h40, bad, 1'b0, 1'b1);
        do_read("R6", d, ref_enc(d) ^ 8'h81, d, 1'b0, 1'b1);
        go_idle();
    endtask

    task automatic t_padded();
        logic [31:0] d = 32'h2468_ACE0;
        do_read("R7", d, ref_enc(d) ^ ref_col(32), d, 1'b0, 1'b1);
        do_read("R7", d, ref_enc(d) ^ ref_col(63), d, 1'b0, 1'b1);
        go_idle();
    endtask

    task automatic t_idle();
        logic [31:0] d = 32'h5555_AAAA;
        logic [7:0] syn_exp;
        syn_exp = ref_col(9);
        do_read("R4", d ^ (32'h1 << 9), ref_enc(d), d, 1'b1, 1'b0);
        go_idle();
        go_idle();
        check("R8", "out_valid", 64'(out_valid), 0);
        check("R8", "out_corrected", 64'(out_corrected), 0);
        check("R8", "out_uncorrectable", 64'(out_uncorrectable), 0);
        check("R8", "out_data held", 64'(out_data), 64'(d));
        check("R8", "out_syndrome held", 64'(out_syndrome), 64'(syn_exp));
    endtask

    task automatic t_back2back();
        logic [31:0] a = 32'h0BAD_CAFE;
        logic [31:0] b = 32'h1111_2222;
        logic [31:0] c = 32'h3333_4444;
        do_read("R9", a ^ 32'h0010_0000, ref_enc(a), a, 1'b1, 1'b0);
        do_read("R9", b ^ 32'h0000_0300, ref_enc(b), b ^ 32'h0000_0300, 1'b0, 1'b1);
        do_read("R9", c, ref_enc(c), c, 1'b0, 1'b0);
        go_idle();
        check("R9", "valid after burst", 64'(out_valid), 0);
    endtask

    task automatic t_concurrent();
        logic [31:0] d = 32'h9ABC_DEF0;
        wr_data = 32'h0F0F_3C3C;
        do_read("R9", d ^ 32'h0000_0040, ref_enc(d), d, 1'b1, 1'b0);
        check("R9", "wr_check during read", 64'(wr_check), 64'(ref_enc(32'h0F0F_3C3C)));
        go_idle();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; rd_valid = 1'b0; rd_data = '0; rd_check = '0; wr_data = '0;
        @(negedge clk);
        t_reset();
        t_encode();
        t_clean();
        t_single_data();
        t_single_check();
        t_double();
        t_padded();
        t_idle();
        t_back2back();
        t_concurrent();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule